// File: doc/BRIEF.md
# Board-Variant System Control Registers

This block is a small bank of system-control registers on a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. A board identity word is fixed when the block is elaborated. The block takes a 12-bit board-type code from that word, and that code sets how the registers behave. It sets which bits can be written, what the registers hold after reset, which write-data bit starts a system reset, and where the write-protect status lands.

The block holds four registers. The first is a lock register that must hold a key before reset control can be written. The second is a reset-control register, which can raise a one-cycle system-reset request. The third is a display-control register, with per-board writable fields and a two-bit display mux output. The fourth is a read-only card-slot status register that samples two level inputs. Software unlocks the block, writes the reset-control register to restart the system, and programs the display register to pick a pixel format.

Top module: `sysctl_board_regs`

## Requirements
- R1: The board type is bits 27:16 of the identity word. The codes 0x100, 0x140, 0x178, 0x182 and 0x190 are recognised, and any other code gets the default behaviour given in R2, R6, R9 and R10.
- R2: After reset the display-control register (offset 0x50) reads 0x0000_0000 on board 0x190 and 0x0000_1F00 on every other board. The reset-control register (offset 0x40), the card-status register and the mux output all read zero after reset.
- R3: The lock register (offset 0x20) keeps the low 16 bits of a write, and reads back that value. The lock is open only while it holds 0xA05F; writing any other value closes it. After reset the lock is closed.
- R4: On board 0x100, a write to offset 0x40 stores all 32 bits only while the lock is open. If write-data bit 8 is set in that write, sys_reset_req is high for exactly the one cycle after the write edge.
- R5: On boards 0x178 and 0x182, writes to offset 0x40 are gated by the lock in the same way, but write-data bit 2 raises the request.
- R6: On any other board, offset 0x40 reads zero, ignores writes and never raises the request.
- R7: On boards 0x100 and 0x140, a display-control write leaves bits 13:8 unchanged and loads every other bit from the write data.
- R8: On board 0x100 only, a display-control write loads write-data bits 1:0 into the disp_mux output. On every other board disp_mux stays 0.
- R9: On boards 0x178 and 0x182, only bit 7 of the display-control register is writable. On board 0x190 and on unrecognised boards, writes to it are ignored.
- R10: The card-status register (offset 0x48) reflects the inputs one cycle after they are sampled. Bit 0 is card_present. card_wprot appears at bit 2 on boards 0x100 and 0x140 and at bit 1 on all other boards. Every other bit is zero, and writes to the register are ignored.
- R11: Reads of an unmapped offset return zero, and writes to one change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| card_present | input | 1 | Card-present level |
| card_wprot | input | 1 | Card write-protect level |
| disp_mux | output | 2 | Display format mux select |
| sys_reset_req | output | 1 | One-cycle system-reset request |

## Verification
The assertions take it that a request pulse can only follow a bus write to the reset-control offset. They also take it that the card inputs are steady across each clock edge, so the status register can be compared with the inputs as they stood one cycle earlier. The stimulus changes inputs only on falling edges and holds bus_wr for a single cycle per write. It runs the same sequence of accesses on six instances at once, one for each recognised board code and one for an unrecognised code.

// File: rtl/sysctl_pkg.sv
// Shared types and constants for the board-variant system control block.
// Assumes a byte-addressed bus of at least 12 address bits.
package sysctl_pkg;

    localparam int unsigned OFF_LOCK   = 32'h020;
    localparam int unsigned OFF_RSTCTL = 32'h040;
    localparam int unsigned OFF_CARD   = 32'h048;
    localparam int unsigned OFF_DISP   = 32'h050;

    localparam logic [15:0] LOCK_KEY       = 16'hA05F;
    localparam logic [31:0] DISP_INIT      = 32'h0000_1F00;
    localparam logic [31:0] DISP_KEEP_WIDE = 32'h0000_3F00;
    localparam logic [31:0] DISP_NARROW_WR = 32'h0000_0080;

    typedef enum logic [2:0] {
        BT_100, BT_140, BT_178, BT_182, BT_190, BT_OTHER
    } board_e;

    typedef struct packed {
        board_e     kind;
        logic       rst_lockable;   // reset-control register implemented
        logic [4:0] rst_trig_bit;   // write-data bit that requests reset
        logic       disp_wide;      // all but bits 13:8 writable
        logic       disp_narrow;    // only bit 7 writable
        logic       disp_mux_en;    // write data drives display mux
        logic       disp_rst_zero;  // display register resets to zero
        logic [4:0] wp_bit;         // card-status bit for write protect
    } board_cfg_t;

    // Map a 12-bit board code onto its behaviour set.
    function automatic board_cfg_t decode_board(input logic [11:0] code);
        board_cfg_t c;
        c = '{kind: BT_OTHER, rst_lockable: 1'b0, rst_trig_bit: 5'd0,
              disp_wide: 1'b0, disp_narrow: 1'b0, disp_mux_en: 1'b0,
              disp_rst_zero: 1'b0, wp_bit: 5'd1};
        case (code)
            12'h100: begin
                c.kind = BT_100; c.rst_lockable = 1'b1; c.rst_trig_bit = 5'd8;
                c.disp_wide = 1'b1; c.disp_mux_en = 1'b1; c.wp_bit = 5'd2;
            end
            12'h140: begin
                c.kind = BT_140; c.disp_wide = 1'b1; c.wp_bit = 5'd2;
            end
            12'h178: begin
                c.kind = BT_178; c.rst_lockable = 1'b1; c.rst_trig_bit = 5'd2;
                c.disp_narrow = 1'b1;
            end
            12'h182: begin
                c.kind = BT_182; c.rst_lockable = 1'b1; c.rst_trig_bit = 5'd2;
                c.disp_narrow = 1'b1;
            end
            12'h190: begin
                c.kind = BT_190; c.disp_rst_zero = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sysctl_board_decode.sv
// Turns the elaboration-time identity word into a board behaviour set.
// Assumes the board-type field sits at bits 27:16 of ID_WORD.
module sysctl_board_decode
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_WORD = 32'h0100_0000
) (
    output board_cfg_t cfg
);
    localparam logic [11:0] BOARD_CODE = ID_WORD[27:16];

    // Constant decode of the board code.
    assign cfg = decode_board(BOARD_CODE);
endmodule

// File: rtl/sysctl_lock.sv
// Lock register: stores a 16-bit key; the gate is open only on the key value.
// Assumes wr_en is already qualified with the lock offset.
module sysctl_lock
    import sysctl_pkg::*;
#(
    parameter int unsigned KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wdata,
    output logic [KEY_W-1:0] lock_q,
    output logic             lock_open
);
    // Hold the last key written; clear on reset so the gate starts closed.
    always_ff @(posedge clk) begin
        if (!rst_n)     lock_q <= '0;
        else if (wr_en) lock_q <= wdata;
    end

    // The gate is open only on an exact key match.
    assign lock_open = (lock_q == KEY_W'(LOCK_KEY));
endmodule

// File: rtl/sysctl_rstctl.sv
// Reset-control register, gated by the lock, with a one-cycle reset request.
// Assumes wr_en is qualified with the reset-control offset and lasts one cycle.
module sysctl_rstctl
    import sysctl_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  board_cfg_t        cfg,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lock_open,
    output logic [DATA_W-1:0] level_q,
    output logic              req
);
    logic accept;

    // A write lands only on boards with the register and an open lock.
    assign accept = wr_en && cfg.rst_lockable && lock_open;

    // Store the accepted value.
    always_ff @(posedge clk) begin
        if (!rst_n)      level_q <= '0;
        else if (accept) level_q <= wdata;
    end

    // Raise the request for the single cycle after an accepted trigger write.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= accept && wdata[cfg.rst_trig_bit];
    end
endmodule

// File: rtl/sysctl_dispctl.sv
// Display-control register with per-board writable fields and a mux output.
// Assumes wr_en is qualified with the display-control offset.
module sysctl_dispctl
    import sysctl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned MUX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  board_cfg_t        cfg,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] disp_q,
    output logic [MUX_W-1:0]  mux_q
);
    localparam logic [DATA_W-1:0] KEEP_WIDE = DATA_W'(DISP_KEEP_WIDE);
    localparam logic [DATA_W-1:0] WR_NARROW = DATA_W'(DISP_NARROW_WR);

    logic [DATA_W-1:0] wr_mask;
    logic [DATA_W-1:0] rst_val;

    // Select the writable bits for this board.
    always_comb begin
        if (cfg.disp_wide)        wr_mask = ~KEEP_WIDE;
        else if (cfg.disp_narrow) wr_mask = WR_NARROW;
        else                      wr_mask = '0;
    end

    // Select the reset value for this board.
    assign rst_val = cfg.disp_rst_zero ? '0 : DATA_W'(DISP_INIT);

    // Merge write data into the writable bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)     disp_q <= rst_val;
        else if (wr_en) disp_q <= (disp_q & ~wr_mask) | (wdata & wr_mask);
    end

    // Load the mux select from the low write-data bits where the board has one.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mux_q <= '0;
        else if (wr_en && cfg.disp_mux_en) mux_q <= wdata[MUX_W-1:0];
    end
endmodule

// File: rtl/sysctl_cardstat.sv
// Card-slot status register: samples two level inputs every cycle.
// Assumes the inputs are already synchronous to clk.
module sysctl_cardstat
    import sysctl_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  board_cfg_t        cfg,
    input  logic              present,
    input  logic              wprot,
    output logic [DATA_W-1:0] stat_q
);
    logic [DATA_W-1:0] stat_d;

    // Place each input at its board-specific bit position.
    always_comb begin
        stat_d = '0;
        stat_d[0] = present;
        stat_d[cfg.wp_bit] = wprot;
    end

    // Sample the status every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end
endmodule

// File: rtl/sysctl_board_regs.sv
// Top of the board-variant system control register block.
// Assumes a single-cycle write strobe and combinational reads.
module sysctl_board_regs
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_WORD = 32'h0100_0000,
    parameter int unsigned ADDR_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              card_present,
    input  logic              card_wprot,
    output logic [1:0]        disp_mux,
    output logic              sys_reset_req
);
    localparam int unsigned DATA_W = 32;
    localparam int unsigned KEY_W  = 16;
    localparam int unsigned MUX_W  = 2;

    board_cfg_t        cfg;
    logic              sel_lock, sel_rst, sel_disp, sel_card;
    logic [KEY_W-1:0]  lock_q;
    logic              lock_open;
    logic [DATA_W-1:0] level_q;
    logic [DATA_W-1:0] disp_q;
    logic [DATA_W-1:0] card_q;

    sysctl_board_decode #(.ID_WORD(ID_WORD)) u_decode (.cfg(cfg));

    // Decode the register selects from the offset.
    assign sel_lock = (bus_addr == ADDR_W'(OFF_LOCK));
    assign sel_rst  = (bus_addr == ADDR_W'(OFF_RSTCTL));
    assign sel_disp = (bus_addr == ADDR_W'(OFF_DISP));
    assign sel_card = (bus_addr == ADDR_W'(OFF_CARD));

    sysctl_lock #(.KEY_W(KEY_W)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && sel_lock),
        .wdata    (bus_wdata[KEY_W-1:0]),
        .lock_q   (lock_q),
        .lock_open(lock_open)
    );

    sysctl_rstctl #(.DATA_W(DATA_W)) u_rstctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .wr_en    (bus_wr && sel_rst),
        .wdata    (bus_wdata),
        .lock_open(lock_open),
        .level_q  (level_q),
        .req      (sys_reset_req)
    );

    sysctl_dispctl #(.DATA_W(DATA_W), .MUX_W(MUX_W)) u_dispctl (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (cfg),
        .wr_en (bus_wr && sel_disp),
        .wdata (bus_wdata),
        .disp_q(disp_q),
        .mux_q (disp_mux)
    );

    sysctl_cardstat #(.DATA_W(DATA_W)) u_cardstat (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg    (cfg),
        .present(card_present),
        .wprot  (card_wprot),
        .stat_q (card_q)
    );

    // Return the selected register; unmapped offsets and absent registers read zero.
    always_comb begin
        bus_rdata = '0;
        if (sel_lock)                     bus_rdata = DATA_W'(lock_q);
        else if (sel_rst && cfg.rst_lockable) bus_rdata = level_q;
        else if (sel_disp)                bus_rdata = disp_q;
        else if (sel_card)                bus_rdata = card_q;
    end
endmodule

// File: rtl/sysctl_board_regs_chk.sv
// Property checker for the board-variant system control block, bound to the top.
// Assumes the card inputs are steady across each clock edge.
module sysctl_board_regs_chk
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              card_present,
    input logic [1:0]        disp_mux,
    input logic              sys_reset_req,
    input board_cfg_t        cfg,
    input logic              lock_open,
    input logic [31:0]       level_q,
    input logic [31:0]       disp_q,
    input logic [31:0]       card_q
);
    logic armed;

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) armed <= rst_n;

    a_r4_req_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> ($past(bus_wr) && $past(bus_addr) == ADDR_W'(OFF_RSTCTL)));

    a_r3_level_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_q) |-> $past(lock_open));

    a_r6_level_absent: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.rst_lockable |-> (level_q == '0 && !sys_reset_req));

    a_r7_field_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.disp_wide || cfg.disp_narrow) |-> (disp_q[13:8] == 6'h1F));

    a_r9_disp_frozen_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.disp_rst_zero |-> (disp_q == '0));

    a_r8_mux_only_first: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.disp_mux_en |-> (disp_mux == 2'b00));

    a_r10_card_follows: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (card_q[0] == $past(card_present)));
endmodule

bind sysctl_board_regs sysctl_board_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .card_present (card_present),
    .disp_mux     (disp_mux),
    .sys_reset_req(sys_reset_req),
    .cfg          (cfg),
    .lock_open    (lock_open),
    .level_q      (level_q),
    .disp_q       (disp_q),
    .card_q       (card_q)
);

// File: tb/sysctl_board_regs_bench.sv
module sysctl_board_regs_bench;
    localparam int NB = 6;

    function automatic logic [11:0] code_of(input int b);
        case (b)
            0: return 12'h100;
            1: return 12'h140;
            2: return 12'h178;
            3: return 12'h182;
            4: return 12'h190;
            default: return 12'h123;
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        card_present = 1'b0;
    logic        card_wprot = 1'b0;
    logic [31:0] rdata_a [NB];
    logic [1:0]  mux_a [NB];
    logic        req_a [NB];

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    for (genvar g = 0; g < NB; g++) begin : gen_board
        sysctl_board_regs #(.ID_WORD({4'h0, code_of(g), 16'h0000}), .ADDR_W(12))
        u_sysctl_board_regs (
            .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
            .bus_wdata(bus_wdata), .bus_rdata(rdata_a[g]),
            .card_present(card_present), .card_wprot(card_wprot),
            .disp_mux(mux_a[g]), .sys_reset_req(req_a[g])
        );
    end

    // Bench model of each board
    logic [31:0] m_disp [NB];
    logic [31:0] m_lvl  [NB];
    logic [1:0]  m_mux  [NB];
    logic        req_seen [NB];

    function automatic bit lockable(input int b);
        return b == 0 || b == 2 || b == 3;
    endfunction

    task automatic chk(input string req, input int b, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s board %h: actual %h expected %h", req, code_of(b), act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        for (int b = 0; b < NB; b++) req_seen[b] = req_a[b];
    endtask

    task automatic read_all(input logic [11:0] a);
        @(negedge clk);
        bus_addr = a;
        #2;
    endtask

    task automatic write_rst(input logic [31:0] d, input bit lock_open);
        bus_write(12'h040, d);
        for (int b = 0; b < NB; b++) begin
            logic exp_req;
            exp_req = 1'b0;
            if (lockable(b) && lock_open) begin
                m_lvl[b] = d;
                exp_req = (b == 0) ? d[8] : d[2];
            end
            chk(b == 0 ? "R4 pulse" : (lockable(b) ? "R5 pulse" : "R6 no pulse"),
                b, {31'b0, req_seen[b]}, {31'b0, exp_req});
        end
        @(negedge clk);
        for (int b = 0; b < NB; b++)
            chk("R4 pulse single cycle", b, {31'b0, req_a[b]}, 32'h0);
        read_all(12'h040);
        for (int b = 0; b < NB; b++)
            chk(lockable(b) ? "R3 R5 reset level" : "R6 reads zero", b, rdata_a[b], m_lvl[b]);
    endtask

    task automatic write_disp(input logic [31:0] d);
        bus_write(12'h050, d);
        for (int b = 0; b < NB; b++) begin
            if (b <= 1)      m_disp[b] = (m_disp[b] & 32'h3F00) | (d & ~32'h3F00);
            else if (b <= 3) m_disp[b] = (m_disp[b] & ~32'h80) | (d & 32'h80);
            if (b == 0) m_mux[b] = d[1:0];
        end
        read_all(12'h050);
        for (int b = 0; b < NB; b++) begin
            chk(b <= 1 ? "R7 display" : "R9 display", b, rdata_a[b], m_disp[b]);
            chk("R8 mux", b, {30'b0, mux_a[b]}, {30'b0, m_mux[b]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_disp[b] = (b == 4) ? 32'h0 : 32'h1F00;
            m_lvl[b] = '0; m_mux[b] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state; R1 decode of each board code
        read_all(12'h050);
        for (int b = 0; b < NB; b++) begin
            chk("R1 R2 display reset", b, rdata_a[b], m_disp[b]);
            chk("R2 mux reset", b, {30'b0, mux_a[b]}, 32'h0);
            chk("R2 no request", b, {31'b0, req_a[b]}, 32'h0);
        end
        read_all(12'h040);
        for (int b = 0; b < NB; b++) chk("R2 reset level", b, rdata_a[b], 32'h0);
        read_all(12'h020);
        for (int b = 0; b < NB; b++) chk("R3 lock reset", b, rdata_a[b], 32'h0);

        // R3 closed lock blocks reset control
        write_rst(32'h0000_0104, 1'b0);

        // R3 open lock, R4/R5/R6 trigger bits
        bus_write(12'h020, 32'hFFFF_A05F);
        read_all(12'h020);
        for (int b = 0; b < NB; b++) chk("R3 lock readback", b, rdata_a[b], 32'h0000_A05F);
        write_rst(32'h0000_0104, 1'b1);
        write_rst(32'h0000_00F0, 1'b1);
        write_rst(32'h0000_0004, 1'b1);
        write_rst(32'h0000_0100, 1'b1);
        write_rst(32'hDEAD_BEEF, 1'b1);

        // R3 any other key closes the lock
        bus_write(12'h020, 32'h0000_1234);
        write_rst(32'h0000_0104, 1'b0);

        // R7 R8 R9 display sweep
        write_disp(32'hFFFF_FFFF);
        write_disp(32'h0000_0000);
        write_disp(32'hA5A5_A5A6);
        write_disp(32'h1234_5681);

        // R10 card status sweep over both inputs
        for (int p = 0; p < 2; p++) begin
            for (int w = 0; w < 2; w++) begin
                @(negedge clk);
                card_present = p[0]; card_wprot = w[0];
                @(negedge clk);
                read_all(12'h048);
                for (int b = 0; b < NB; b++)
                    chk("R10 card status", b, rdata_a[b],
                        32'(p) | (32'(w) << ((b <= 1) ? 2 : 1)));
                bus_write(12'h048, 32'hFFFF_FFFF);
                read_all(12'h048);
                for (int b = 0; b < NB; b++)
                    chk("R10 write ignored", b, rdata_a[b],
                        32'(p) | (32'(w) << ((b <= 1) ? 2 : 1)));
            end
        end

        // R11 unmapped offsets
        bus_write(12'h010, 32'hFFFF_FFFF);
        bus_write(12'h0A4, 32'hFFFF_FFFF);
        read_all(12'h010);
        for (int b = 0; b < NB; b++) chk("R11 unmapped read", b, rdata_a[b], 32'h0);
        read_all(12'h050);
        for (int b = 0; b < NB; b++) chk("R11 display untouched", b, rdata_a[b], m_disp[b]);
        read_all(12'h040);
        for (int b = 0; b < NB; b++) chk("R11 level untouched", b, rdata_a[b], m_lvl[b]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule